// File: doc/BRIEF.md
# Up-Counting Timer with Rising/Falling Capture

This block is a free-running or self-clearing up-counter with two capture registers. A byte-wide mode register sets its behaviour. Software writes the mode register and a 16-bit compare register over a small write-only register bus. The count, both capture registers and two interrupt pulses come out as ports.

The counter advances on one of four sources. The first is a synchronized rising edge of an external pin. The other three are a base tick taken directly, or divided by four or by sixteen. When clear-on-match is enabled, the counter returns to zero on the tick where it equals the compare value. The capture unit copies the running count into capture register 0 or capture register 1. It is triggered by edges of the external pin, by edges of a neighbouring timer's output, or by a software command carried in the mode-register write. The block also raises an external-pin interrupt. The capture mode chooses which edge of the pin triggers it.

Top module: `capture_timer`

## Requirements
- R1: After synchronous reset, count, capture 0, capture 1, the compare value, the mode fields and both interrupt outputs are zero.
- R2: Mode bits [1:0] select the count source. 01 advances on every base tick. 10 advances on every fourth base tick. 11 advances on every sixteenth. 00 advances once per synchronized rising edge of the external pin and ignores base ticks.
- R3: With mode bit 2 set, the counter goes to zero on the count event at which it equals the compare register (address 1). With bit 2 clear, it counts through the compare value.
- R4: `cmp_irq` is a pulse one clock long, raised after each count event at which the count equals the compare value.
- R5: While `run_en` is low, the count holds.
- R6: Capture mode (bits [4:3]) 01 copies the count into capture 0 on each rising edge of the external pin. Mode 00 performs no hardware capture. The value captured is the count before that cycle's update.
- R7: Capture mode 10 captures on external-pin edges: rising edges go to capture 0 and falling edges to capture 1. Capture mode 11 captures on neighbour-output edges in the same way and ignores the external pin. Capture registers hold their value between captures.
- R8: A write to the mode register (address 0) with bit 5 equal to 0 copies the count into capture 0. With bit 5 equal to 1, capture 0 is left alone. This software capture takes priority over a hardware capture into capture 0 in the same cycle.
- R9: `ext_irq` pulses for one clock on a synchronized rising edge of the external pin in capture modes 00, 01 and 11. In capture mode 10 it pulses on a falling edge instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable |
| base_tick | input | 1 | Undivided prescaler tick, one cycle wide |
| ext_pin | input | 1 | External pin, asynchronous |
| nbr_out | input | 1 | Neighbouring timer output, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = mode byte, 1 = compare value |
| wr_data | input | 16 | Write data; the mode uses bits [7:0] |
| count | output | 16 | Current counter value |
| cap0 | output | 16 | Capture register 0 |
| cap1 | output | 16 | Capture register 1 |
| cmp_irq | output | 1 | Compare-match interrupt pulse |
| ext_irq | output | 1 | External-pin interrupt pulse |

## Verification
A hardware capture and a clear-by-match can land on the same clock edge. The capture must then hold the compare value, while the counter reads zero. The bench provokes this by raising the external pin first. It then times a base tick so that it arrives exactly when the synchronized edge reaches the capture logic, with the count already equal to the compare value. It judges the outcome by checking four things after that edge: count zero, capture 0 equal to the compare value, and both interrupt pulses high.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        CK_PIN   = 2'b00,
        CK_DIV1  = 2'b01,
        CK_DIV4  = 2'b10,
        CK_DIV16 = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        CAP_OFF      = 2'b00,
        CAP_PIN_RISE = 2'b01,
        CAP_PIN_BOTH = 2'b10,
        CAP_NBR_BOTH = 2'b11
    } cap_mode_e;

    typedef struct packed {
        cap_mode_e capm;
        logic      clr_en;
        clk_sel_e  clksel;
    } mode_cfg_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_CMP  = 2'd1;
    localparam int         SWCAP_BIT = 5;

    // Interrupt edge follows the capture mode: only the dual-edge pin mode
    // moves the request to the falling edge.
    function automatic logic irq_edge(input cap_mode_e m, input edge_t e);
        return (m == CAP_PIN_BOTH) ? e.fall : e.rise;
    endfunction

    function automatic mode_cfg_t decode_mode(input logic [7:0] b);
        mode_cfg_t c;
        c.clksel = clk_sel_e'(b[1:0]);
        c.clr_en = b[2];
        c.capm   = cap_mode_e'(b[4:3]);
        return c;
    endfunction

endpackage

// File: rtl/ctmr_edge_sync.sv
module ctmr_edge_sync
    import ctmr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  d,
    output logic  level,
    output edge_t edges
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            prev <= 1'b0;
        end else begin
            sh   <= {sh[STAGES-2:0], d};
            prev <= sh[STAGES-1];
        end
    end

    assign level      = sh[STAGES-1];
    assign edges.rise = sh[STAGES-1] & ~prev;
    assign edges.fall = ~sh[STAGES-1] & prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        edges.rise |=> !edges.rise); // R2

endmodule

// File: rtl/ctmr_tick_sel.sv
module ctmr_tick_sel
    import ctmr_pkg::*;
#(
    parameter int PRE_W  = 4,
    parameter int DIV_A  = 2,
    parameter int DIV_B  = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     base_tick,
    input  logic     pin_rise,
    input  clk_sel_e sel,
    output logic     tick
);
    logic [PRE_W-1:0] pre;
    logic [1:0]       div_tick;
    logic [1:0][PRE_W-1:0] div_mask;

    assign div_mask[0] = PRE_W'((1 << DIV_A) - 1);
    assign div_mask[1] = PRE_W'((1 << DIV_B) - 1);

    always_ff @(posedge clk) begin
        if (rst)            pre <= '0;
        else if (base_tick) pre <= pre + 1'b1;
    end

    for (genvar i = 0; i < 2; i++) begin : g_div
        assign div_tick[i] = base_tick && ((pre & div_mask[i]) == div_mask[i]);
    end

    always_comb begin
        unique case (sel)
            CK_PIN:   tick = pin_rise;
            CK_DIV1:  tick = base_tick;
            CK_DIV4:  tick = div_tick[0];
            default:  tick = div_tick[1];
        endcase
    end

    AST_DIV_NEEDS_BASE: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != CK_PIN) |-> base_tick); // R2

endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run_en,
    input  logic         clr_en,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt,
    output logic         match_irq
);
    logic step;
    logic hit;

    assign step = tick && run_en;
    assign hit  = (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            match_irq <= 1'b0;
        end else begin
            match_irq <= step && hit;
            if (step) cnt <= (clr_en && hit) ? '0 : cnt + 1'b1;
        end
    end

    AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
        (step && clr_en && hit) |=> (cnt == '0)); // R3
    AST_HOLD_NO_RUN: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(cnt)); // R5
    AST_MATCH_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(match_irq) |-> $past(run_en)); // R4

endmodule

// File: rtl/ctmr_capture.sv
module ctmr_capture
    import ctmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  cap_mode_e    capm,
    input  edge_t        pin_e,
    input  edge_t        nbr_e,
    input  logic         sw_cap,
    output logic [W-1:0] cap0,
    output logic [W-1:0] cap1
);
    logic hw0, hw1;

    always_comb begin
        hw0 = 1'b0;
        hw1 = 1'b0;
        unique case (capm)
            CAP_OFF:      ;
            CAP_PIN_RISE: hw0 = pin_e.rise;
            CAP_PIN_BOTH: begin hw0 = pin_e.rise; hw1 = pin_e.fall; end
            default:      begin hw0 = nbr_e.rise; hw1 = nbr_e.fall; end
        endcase
    end

    // Software capture wins over a hardware capture into register 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            cap0 <= '0;
            cap1 <= '0;
        end else begin
            if (sw_cap || hw0) cap0 <= cnt;
            if (hw1)           cap1 <= cnt;
        end
    end

    AST_CAP1_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hw1 |=> $stable(cap1)); // R7
    AST_SW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        sw_cap |=> (cap0 == $past(cnt))); // R8
    AST_CAP_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
        (capm == CAP_OFF && !sw_cap) |=> $stable(cap0)); // R6

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import ctmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SYNC_LEN = 2,
    parameter int PRE_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             base_tick,
    input  logic             ext_pin,
    input  logic             nbr_out,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap0,
    output logic [CNT_W-1:0] cap1,
    output logic             cmp_irq,
    output logic             ext_irq
);
    localparam int N_SYNC = 2;

    mode_cfg_t        mode_q;
    logic [CNT_W-1:0] cmp_q;
    logic             mode_wr;
    logic             sw_cap;
    logic             tick;
    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] lvl;
    edge_t            edg [N_SYNC];

    assign mode_wr = wr_en && (wr_addr == ADDR_MODE);
    assign sw_cap  = mode_wr && !wr_data[SWCAP_BIT];
    assign raw_in  = {nbr_out, ext_pin};

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cmp_q  <= '0;
        end else begin
            if (mode_wr)                          mode_q <= decode_mode(wr_data[7:0]);
            if (wr_en && wr_addr == ADDR_CMP)     cmp_q  <= wr_data;
        end
    end

    for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
        ctmr_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .d     (raw_in[i]),
            .level (lvl[i]),
            .edges (edg[i])
        );
    end

    ctmr_tick_sel #(.PRE_W(PRE_W)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .pin_rise  (edg[0].rise),
        .sel       (mode_q.clksel),
        .tick      (tick)
    );

    ctmr_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .run_en    (run_en),
        .clr_en    (mode_q.clr_en),
        .cmp       (cmp_q),
        .cnt       (count),
        .match_irq (cmp_irq)
    );

    ctmr_capture #(.W(CNT_W)) u_cap (
        .clk    (clk),
        .rst    (rst),
        .cnt    (count),
        .capm   (mode_q.capm),
        .pin_e  (edg[0]),
        .nbr_e  (edg[1]),
        .sw_cap (sw_cap),
        .cap0   (cap0),
        .cap1   (cap1)
    );

    always_ff @(posedge clk) begin
        if (rst) ext_irq <= 1'b0;
        else     ext_irq <= irq_edge(mode_q.capm, edg[0]);
    end

    AST_EXT_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        ext_irq |=> !ext_irq); // R9
    AST_EXT_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ext_irq |-> (lvl[0] == (mode_q.capm != CAP_PIN_BOTH))); // R9

endmodule

// File: tb/sim_capture_timer.sv
module sim_capture_timer;
    import ctmr_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        base_tick = 1'b0;
    logic        ext_pin = 1'b0;
    logic        nbr_out = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count, cap0, cap1;
    logic        cmp_irq, ext_irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    capture_timer u0 (
        .clk(clk), .rst(rst), .run_en(run_en), .base_tick(base_tick),
        .ext_pin(ext_pin), .nbr_out(nbr_out), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .count(count),
        .cap0(cap0), .cap1(cap1), .cmp_irq(cmp_irq), .ext_irq(ext_irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ext_pin = 1'b0; nbr_out = 1'b0; base_tick = 1'b0; wr_en = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [7:0] m);
        wr(ADDR_MODE, {8'h00, m | 8'h20});
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); base_tick = 1'b1;
            @(negedge clk); base_tick = 1'b0;
        end
    endtask

    // Drive a pin level, sample ext_irq at the cycle the synced edge acts.
    task automatic drive_pin(input bit nbr, input logic v, output logic irq);
        @(negedge clk);
        if (nbr) nbr_out = v; else ext_pin = v;
        repeat (3) @(negedge clk);
        irq = ext_irq;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count, 16'h0);
        chk("R1 cap0", cap0, 16'h0);
        chk("R1 cap1", cap1, 16'h0);
        chk("R1 cmp_irq", {15'h0, cmp_irq}, 16'h0);
        chk("R1 ext_irq", {15'h0, ext_irq}, 16'h0);
    endtask

    task automatic t_clksel();
        logic irq;
        do_reset();
        run_en = 1'b1;
        set_mode(8'h01); tick(5);
        chk("R2 div1", count, 16'd5);
        set_mode(8'h02); tick(16);
        chk("R2 div4", count, 16'd9);
        set_mode(8'h03); tick(16);
        chk("R2 div16", count, 16'd10);
        set_mode(8'h00);
        for (int i = 0; i < 3; i++) begin
            drive_pin(1'b0, 1'b1, irq);
            drive_pin(1'b0, 1'b0, irq);
        end
        chk("R2 pin clock", count, 16'd13);
        tick(4);
        chk("R2 pin mode ignores ticks", count, 16'd13);
    endtask

    task automatic t_clear_runen();
        do_reset();
        run_en = 1'b1;
        wr(ADDR_CMP, 16'd3);
        set_mode(8'h05);
        tick(3);
        chk("R3 before match", count, 16'd3);
        @(negedge clk); base_tick = 1'b1;
        @(negedge clk); base_tick = 1'b0;
        chk("R3 cleared on match", count, 16'd0);
        chk("R4 match pulse", {15'h0, cmp_irq}, 16'h1);
        @(negedge clk);
        chk("R4 pulse one cycle", {15'h0, cmp_irq}, 16'h0);
        set_mode(8'h01);
        tick(5);
        chk("R3 free run passes compare", count, 16'd5);
        run_en = 1'b0;
        tick(4);
        chk("R5 hold when disabled", count, 16'd5);
        run_en = 1'b1;
    endtask

    task automatic t_capture();
        logic irq;
        do_reset();
        run_en = 1'b1;
        set_mode(8'h09); tick(7);
        drive_pin(1'b0, 1'b1, irq);
        chk("R6 rise to cap0", cap0, 16'd7);
        chk("R9 rise irq mode01", {15'h0, irq}, 16'h1);
        drive_pin(1'b0, 1'b0, irq);
        chk("R6 fall ignored mode01", cap1, 16'd0);
        set_mode(8'h01); tick(2);
        drive_pin(1'b0, 1'b1, irq);
        chk("R6 mode00 no capture", cap0, 16'd7);
        chk("R9 rise irq mode00", {15'h0, irq}, 16'h1);
        set_mode(8'h11); tick(2);
        drive_pin(1'b0, 1'b0, irq);
        chk("R7 fall to cap1", cap1, 16'd11);
        chk("R9 fall irq mode10", {15'h0, irq}, 16'h1);
        tick(3);
        drive_pin(1'b0, 1'b1, irq);
        chk("R7 rise to cap0 mode10", cap0, 16'd14);
        chk("R9 no rise irq mode10", {15'h0, irq}, 16'h0);
        set_mode(8'h19); tick(1);
        drive_pin(1'b0, 1'b0, irq);
        chk("R7 pin ignored mode11", cap1, 16'd11);
        chk("R9 no fall irq mode11", {15'h0, irq}, 16'h0);
        drive_pin(1'b0, 1'b1, irq);
        chk("R7 pin rise ignored mode11", cap0, 16'd14);
        chk("R9 rise irq mode11", {15'h0, irq}, 16'h1);
        drive_pin(1'b1, 1'b1, irq);
        chk("R7 nbr rise to cap0", cap0, 16'd15);
        tick(1);
        drive_pin(1'b1, 1'b0, irq);
        chk("R7 nbr fall to cap1", cap1, 16'd16);
    endtask

    task automatic t_swcap();
        tick(4);
        wr(ADDR_MODE, 16'h0019);
        chk("R8 sw capture", cap0, 16'd20);
        tick(1);
        wr(ADDR_MODE, 16'h0039);
        chk("R8 bit5 set no capture", cap0, 16'd20);
        chk("R8 count unaffected", count, 16'd21);
    endtask

    task automatic t_collide();
        do_reset();
        run_en = 1'b1;
        wr(ADDR_CMP, 16'd5);
        set_mode(8'h0D);
        tick(5);
        chk("R3 at compare", count, 16'd5);
        @(negedge clk); ext_pin = 1'b1;
        @(negedge clk);
        @(negedge clk); base_tick = 1'b1;
        @(negedge clk); base_tick = 1'b0;
        chk("R3 collide cleared", count, 16'd0);
        chk("R6 collide captures pre-clear value", cap0, 16'd5);
        chk("R4 collide match pulse", {15'h0, cmp_irq}, 16'h1);
        chk("R9 collide ext irq", {15'h0, ext_irq}, 16'h1);
    endtask

    initial begin
        t_reset();
        t_clksel();
        t_clear_runen();
        t_capture();
        t_swcap();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule